// File: doc/BRIEF.md
# I2C Host Bus Error Monitor

This block runs alongside the bit engine of an I2C host and compares what the host drives onto the open-drain SCL and SDA wires with what actually appears on them. It catches three bus faults. Another device may pull a line low that the host has released. SDA may move while SCL is high during a receive bit. A target may stretch SCL low for longer than a programmed count. Each fault latches a sticky flag that software clears bit by bit.

The raw wires pass through a two-flop synchronizer. After any change in the host's own drive, a programmable settle window masks comparisons. This hides the synchronizer lag and the wire rise time. A watcher state machine follows the SCL cycle through four states:

- `W_IDLE`: no host transfer is in progress, or override is on.
- `W_DRIVE_LOW`: the host holds SCL low.
- `W_STRETCH`: the host has released SCL but SCL is still seen low.
- `W_HIGH`: SCL is seen high.

The transitions are:

- `W_IDLE` goes to `W_DRIVE_LOW` or `W_STRETCH` when a phase becomes active. Which one depends on the host SCL drive.
- `W_DRIVE_LOW` goes to `W_STRETCH` when the host releases SCL.
- `W_STRETCH` goes to `W_HIGH` when SCL is seen high and the settle window has expired.
- `W_HIGH` goes to `W_STRETCH` when SCL drops while the host is still releasing it and the window has expired.
- `W_STRETCH` and `W_HIGH` go to `W_DRIVE_LOW` when the host pulls SCL low.
- Every state goes to `W_IDLE` when the phase is no longer active or override is set.

An override input takes the two output enables away from the engine and forces them from register values. A synchronous soft clear resets the flags, the counters and the watcher without a bus reset.

Top module: `i2c_bus_watch`

## Requirements
- R1: Line comparisons use only the synchronized lines. Mismatches are ignored while the settle counter runs. The counter is loaded with `settle_cycles` on every change of either output enable and then counts down to zero.
- R2: `flags_o[0]` (SCL interference) sets when SCL is seen low in `W_HIGH` while the host releases SCL. It sets in both active phases. A low SCL after the host release but before SCL is first seen high is a stretch and does not set the flag.
- R3: `flags_o[1]` (SDA interference) sets when, in transmit phase (`phase_i` = 1), SDA is seen low during the SCL high pulse while the host releases SDA. It stays clear when the host itself drives SDA low.
- R4: `flags_o[2]` (SDA unstable) sets when, in receive phase (`phase_i` = 2), SDA changes value while SCL is high.
- R5: Each flag stays set until its own bit of `clr_i` is pulsed. Clearing one bit leaves the other flags unchanged. A set condition and a clear in the same cycle leave the flag set.
- R6: When `stretch_en` is 1, a target holding SCL low after the host released it for `stretch_limit` cycles (limit ≥ 1) gives exactly one single-cycle `stretch_evt_o` pulse and sets `flags_o[3]`. The count then saturates. When `stretch_en` is 0, nothing is counted.
- R7: The stretch count restarts from zero whenever SCL is seen high. Two separate low periods, each shorter than the limit, never fire.
- R8: When `ovr_en` is 1, `scl_oe_o` = !`ovr_scl` and `sda_oe_o` = !`ovr_sda`, whatever the host enables are. No new fault is flagged. An enable of 1 means the line is pulled low.
- R9: A one-cycle `soft_clr` clears all flags and restarts the stretch count and the watcher.
- R10: In idle phase (`phase_i` = 0 or 3), no fault sets any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of flags, counters and watcher |
| scl_i | input | 1 | Raw SCL wire level |
| sda_i | input | 1 | Raw SDA wire level |
| host_scl_oe | input | 1 | Engine SCL drive, 1 = pull low |
| host_sda_oe | input | 1 | Engine SDA drive, 1 = pull low |
| phase_i | input | 2 | 0/3 idle, 1 transmit, 2 receive |
| ovr_en | input | 1 | Override mode enable |
| ovr_scl | input | 1 | Forced SCL level in override |
| ovr_sda | input | 1 | Forced SDA level in override |
| stretch_en | input | 1 | Stretch timeout enable |
| stretch_limit | input | CNT_W | Stretch timeout in cycles |
| settle_cycles | input | SETTLE_W | Mask window after a drive change |
| clr_i | input | 4 | Per-flag clear strobes |
| scl_oe_o | output | 1 | Final SCL drive, 1 = pull low |
| sda_oe_o | output | 1 | Final SDA drive, 1 = pull low |
| flags_o | output | 4 | Sticky flags: 0 SCL interference, 1 SDA interference, 2 SDA unstable, 3 stretch timeout |
| stretch_evt_o | output | 1 | Single-cycle stretch timeout event |

## Verification
The bench goes after the boundaries between a legal stretch and SCL interference, and between a target pulling a released SDA and the host driving SDA low itself. A watcher that confused these would flag every normal clock stretch, or every transmitted zero bit.

It holds a mismatch inside a long settle window to catch a mask that ignores drive changes. It splits a long stretch with a high pulse to catch a counter that never restarts. It holds SCL low well past the limit to catch a counter that wraps and fires twice. It pulses a clear while a fault persists to catch a clear that wins over a set.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TX   = 2'd1,
        PH_RX   = 2'd2,
        PH_RSVD = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_DRIVE_LOW,
        W_STRETCH,
        W_HIGH
    } watch_st_e;

    localparam int FLG_SCL_INTF = 0;
    localparam int FLG_SDA_INTF = 1;
    localparam int FLG_SDA_UNST = 2;
    localparam int FLG_STRETCH  = 3;
    localparam int FLG_COUNT    = 4;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_settle_timer.sv
module i2c_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         kick_i,
    input  logic [W-1:0] load_i,
    output logic         quiet_o
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (soft_clr) begin
            left_q <= '0;
        end else if (kick_i) begin
            left_q <= load_i;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign quiet_o = (left_q == '0) && !kick_i;
endmodule

// File: rtl/i2c_stretch_timer.sv
module i2c_stretch_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o,
    output logic         evt_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;
    assign hit_o   = run_i && (limit_i != '0) && (cnt_q != limit_i) && (cnt_inc == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_o <= 1'b0;
        end else if (soft_clr) begin
            cnt_q <= '0;
            evt_o <= 1'b0;
        end else begin
            evt_o <= hit_o;
            if (!run_i) begin
                cnt_q <= '0;
            end else if (cnt_q != limit_i) begin
                cnt_q <= cnt_inc;
            end
        end
    end
endmodule

// File: rtl/i2c_sticky_flags.sv
module i2c_sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (soft_clr) begin
                flag_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SETTLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_clr,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 host_scl_oe,
    input  logic                 host_sda_oe,
    input  logic [1:0]           phase_i,
    input  logic                 ovr_en,
    input  logic                 ovr_scl,
    input  logic                 ovr_sda,
    input  logic                 stretch_en,
    input  logic [CNT_W-1:0]     stretch_limit,
    input  logic [SETTLE_W-1:0]  settle_cycles,
    input  logic [3:0]           clr_i,
    output logic                 scl_oe_o,
    output logic                 sda_oe_o,
    output logic [3:0]           flags_o,
    output logic                 stretch_evt_o
);
    localparam int NFLG = FLG_COUNT;

    watch_st_e        state_q, state_d;
    phase_e           phase;
    logic             active;
    logic             scl_s, sda_s, sda_prev_q;
    logic [1:0]       oe_prev_q;
    logic             kick, quiet;
    logic             run, hit;
    logic [NFLG-1:0]  set_vec;

    // Final drive with override
    assign scl_oe_o = ovr_en ? !ovr_scl : host_scl_oe;
    assign sda_oe_o = ovr_en ? !ovr_sda : host_sda_oe;

    assign phase  = phase_e'(phase_i);
    assign active = !ovr_en && ((phase == PH_TX) || (phase == PH_RX));

    i2c_line_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_prev_q  <= 2'b00;
            sda_prev_q <= 1'b1;
        end else begin
            oe_prev_q  <= {scl_oe_o, sda_oe_o};
            sda_prev_q <= sda_s;
        end
    end

    assign kick = ({scl_oe_o, sda_oe_o} != oe_prev_q);

    i2c_settle_timer #(.W(SETTLE_W)) i_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .kick_i   (kick),
        .load_i   (settle_cycles),
        .quiet_o  (quiet)
    );

    assign run = stretch_en && (state_q == W_STRETCH) && !scl_s;

    i2c_stretch_timer #(.W(CNT_W)) i_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .run_i    (run),
        .limit_i  (stretch_limit),
        .hit_o    (hit),
        .evt_o    (stretch_evt_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else if (soft_clr) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (active) state_d = scl_oe_o ? W_DRIVE_LOW : W_STRETCH;
            end
            W_DRIVE_LOW: begin
                if (!active)        state_d = W_IDLE;
                else if (!scl_oe_o) state_d = W_STRETCH;
            end
            W_STRETCH: begin
                if (!active)             state_d = W_IDLE;
                else if (scl_oe_o)       state_d = W_DRIVE_LOW;
                else if (scl_s && quiet) state_d = W_HIGH;
            end
            W_HIGH: begin
                if (!active)              state_d = W_IDLE;
                else if (scl_oe_o)        state_d = W_DRIVE_LOW;
                else if (!scl_s && quiet) state_d = W_STRETCH;
            end
        endcase
    end

    // Fault detection outputs
    always_comb begin
        set_vec               = '0;
        set_vec[FLG_SCL_INTF] = (state_q == W_HIGH) && !scl_oe_o && quiet && !scl_s;
        set_vec[FLG_SDA_INTF] = (state_q == W_HIGH) && (phase == PH_TX) && !sda_oe_o
                                && quiet && !sda_s;
        set_vec[FLG_SDA_UNST] = (state_q == W_HIGH) && (phase == PH_RX) && quiet
                                && (sda_s != sda_prev_q);
        set_vec[FLG_STRETCH]  = hit;
    end

    i2c_sticky_flags #(.N(NFLG)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .set_i    (set_vec),
        .clr_i    (clr_i),
        .flag_o   (flags_o)
    );
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_clr,
    input logic [1:0] phase_i,
    input logic       ovr_en,
    input logic       stretch_en,
    input logic [3:0] clr_i,
    input logic [3:0] flags_o,
    input logic       stretch_evt_o
);
    for (genvar i = 0; i < 4; i++) begin : g_sticky
        // R5
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[i] && !clr_i[i] && !soft_clr) |=> flags_o[i]);
    end

    // R6
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_evt_o |=> !stretch_evt_o);

    // R6
    evt_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_evt_o |-> $past(stretch_en));

    // R6
    evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_evt_o |-> flags_o[3]);

    // R8
    ovr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && $past(ovr_en)) |=> ($countones(flags_o & ~$past(flags_o)) == 0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_i == 2'd0) && ($past(phase_i) == 2'd0)) |=> ($countones(flags_o & ~$past(flags_o)) == 0));

    // R9
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (flags_o == 4'b0000) && !stretch_evt_o);
endmodule

bind i2c_bus_watch i2c_bus_watch_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_clr      (soft_clr),
    .phase_i       (phase_i),
    .ovr_en        (ovr_en),
    .stretch_en    (stretch_en),
    .clr_i         (clr_i),
    .flags_o       (flags_o),
    .stretch_evt_o (stretch_evt_o)
);

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        host_scl_oe = 1'b0, host_sda_oe = 1'b0;
    logic        tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
    logic [1:0]  phase_i = 2'd0;
    logic        ovr_en = 1'b0, ovr_scl = 1'b1, ovr_sda = 1'b1;
    logic        stretch_en = 1'b1;
    logic [15:0] stretch_limit = 16'd40;
    logic [7:0]  settle_cycles = 8'd4;
    logic [3:0]  clr_i = 4'b0;
    logic        scl_oe_o, sda_oe_o, stretch_evt_o;
    logic [3:0]  flags_o;
    logic        scl_i, sda_i;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_i = !(scl_oe_o || tgt_scl_low);
    assign sda_i = !(sda_oe_o || tgt_sda_low);

    i2c_bus_watch i_i2c_bus_watch (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .scl_i(scl_i), .sda_i(sda_i),
        .host_scl_oe(host_scl_oe), .host_sda_oe(host_sda_oe),
        .phase_i(phase_i), .ovr_en(ovr_en), .ovr_scl(ovr_scl), .ovr_sda(ovr_sda),
        .stretch_en(stretch_en), .stretch_limit(stretch_limit),
        .settle_cycles(settle_cycles), .clr_i(clr_i),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .flags_o(flags_o), .stretch_evt_o(stretch_evt_o)
    );

    // {phase[1:0], kind[1:0], bit, expected flags[3:0]}
    // kind: 0 none, 1 target pulls SCL, 2 target pulses SDA low, 3 target toggles SDA
    localparam logic [8:0] VEC [8] = '{
        {2'd1, 2'd0, 1'b1, 4'b0000},   // R3 clean TX
        {2'd1, 2'd1, 1'b1, 4'b0001},   // R2 TX
        {2'd1, 2'd2, 1'b1, 4'b0010},   // R3
        {2'd1, 2'd2, 1'b0, 4'b0000},   // R3 host drives low
        {2'd2, 2'd0, 1'b1, 4'b0000},   // R4 clean RX
        {2'd2, 2'd3, 1'b1, 4'b0100},   // R4
        {2'd2, 2'd1, 1'b0, 4'b0001},   // R2 RX
        {2'd0, 2'd1, 1'b1, 4'b0000}    // R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        clr_i = 4'hF;
        wait_n(1);
        clr_i = 4'h0;
        wait_n(1);
    endtask

    task automatic run_bit(input logic [1:0] ph, input logic [1:0] kind, input logic bv);
        phase_i     = ph;
        host_scl_oe = 1'b1;
        host_sda_oe = (ph == 2'd1) ? !bv : 1'b0;
        tgt_sda_low = (ph == 2'd2) ? !bv : 1'b0;
        wait_n(8);
        host_scl_oe = 1'b0;
        wait_n(12);
        if (kind == 2'd1) begin
            tgt_scl_low = 1'b1; wait_n(3); tgt_scl_low = 1'b0;
        end else if (kind == 2'd2) begin
            tgt_sda_low = 1'b1; wait_n(3); tgt_sda_low = 1'b0;
        end else if (kind == 2'd3) begin
            tgt_sda_low = !tgt_sda_low; wait_n(3); tgt_sda_low = !tgt_sda_low;
        end
        wait_n(12);
        host_scl_oe = 1'b1;
        wait_n(8);
        tgt_sda_low = 1'b0;
        host_sda_oe = 1'b0;
        wait_n(4);
        phase_i     = 2'd0;
        host_scl_oe = 1'b0;
        wait_n(6);
    endtask

    // Host releases SCL while the target holds it low for hold cycles; returns event count
    task automatic stretch_run(input int hold, input int clr_at, output int evts);
        evts = 0;
        phase_i = 2'd1;
        host_scl_oe = 1'b1;
        wait_n(8);
        tgt_scl_low = 1'b1;
        host_scl_oe = 1'b0;
        for (int k = 0; k < hold; k++) begin
            soft_clr = (k == clr_at);
            @(negedge clk);
            if (stretch_evt_o) evts++;
        end
        soft_clr = 1'b0;
        tgt_scl_low = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (stretch_evt_o) evts++;
        end
        host_scl_oe = 1'b1;
        wait_n(4);
        phase_i = 2'd0;
        host_scl_oe = 1'b0;
        wait_n(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        // Reset state
        chk("R5 reset flags", flags_o, 4'b0000);
        chk("R6 reset event", stretch_evt_o, 1'b0);
        chk("R8 pass-through", {scl_oe_o, sda_oe_o}, 2'b00);

        // Table of bit patterns
        foreach (VEC[i]) begin
            run_bit(VEC[i][8:7], VEC[i][6:5], VEC[i][4]);
            chk($sformatf("R2/R3/R4/R10 vector %0d", i), flags_o, VEC[i][3:0]);
            clear_all();
            chk($sformatf("R5 clear after vector %0d", i), flags_o, 4'b0000);
        end

        // R5: set and clear in the same cycle, selective clear, stickiness
        phase_i = 2'd1; host_scl_oe = 1'b1; host_sda_oe = 1'b0;
        wait_n(8);
        host_scl_oe = 1'b0;
        wait_n(12);
        tgt_sda_low = 1'b1;
        wait_n(10);
        clr_i = 4'b0010; wait_n(1); clr_i = 4'b0000;
        chk("R5 set beats clear", flags_o[1], 1'b1);
        tgt_sda_low = 1'b0;
        wait_n(30);
        chk("R5 sticky hold", flags_o[1], 1'b1);
        clr_i = 4'b1101; wait_n(1); clr_i = 4'b0000;
        chk("R5 other clears leave bit", flags_o, 4'b0010);
        clr_i = 4'b0010; wait_n(1); clr_i = 4'b0000;
        chk("R5 own clear", flags_o, 4'b0000);
        host_scl_oe = 1'b1; wait_n(4); phase_i = 2'd0; host_scl_oe = 1'b0; wait_n(6);

        // R1: mismatch masked inside a long settle window
        settle_cycles = 8'd30;
        phase_i = 2'd1; host_scl_oe = 1'b1; host_sda_oe = 1'b1;
        wait_n(8);
        host_scl_oe = 1'b0;
        wait_n(40);
        tgt_sda_low = 1'b1;
        wait_n(5);
        host_sda_oe = 1'b0;
        wait_n(15);
        chk("R1 masked in settle window", flags_o[1], 1'b0);
        wait_n(30);
        chk("R1 flagged after window", flags_o[1], 1'b1);
        tgt_sda_low = 1'b0; host_scl_oe = 1'b1; wait_n(4);
        phase_i = 2'd0; host_scl_oe = 1'b0; settle_cycles = 8'd4; wait_n(6);
        clear_all();

        // R6: stretch timeout
        stretch_limit = 16'd20;
        stretch_run(60, -1, n);
        chk("R6 single event", n, 1);
        chk("R6 flag set", flags_o[3], 1'b1);
        clear_all();
        stretch_run(10, -1, n);
        chk("R6 short hold no event", n, 0);
        chk("R6 short hold no flag", flags_o[3], 1'b0);
        stretch_en = 1'b0;
        stretch_run(60, -1, n);
        chk("R6 disabled no event", n, 0);
        chk("R6 disabled no flag", flags_o[3], 1'b0);
        stretch_en = 1'b1;
        clear_all();

        // R7: two short lows separated by a high pulse
        n = 0;
        phase_i = 2'd1; host_scl_oe = 1'b1; wait_n(8);
        tgt_scl_low = 1'b1; host_scl_oe = 1'b0;
        for (int k = 0; k < 12; k++) begin @(negedge clk); if (stretch_evt_o) n++; end
        tgt_scl_low = 1'b0;
        for (int k = 0; k < 12; k++) begin @(negedge clk); if (stretch_evt_o) n++; end
        tgt_scl_low = 1'b1;
        for (int k = 0; k < 12; k++) begin @(negedge clk); if (stretch_evt_o) n++; end
        tgt_scl_low = 1'b0;
        for (int k = 0; k < 12; k++) begin @(negedge clk); if (stretch_evt_o) n++; end
        chk("R7 count restarts on high", n, 0);
        chk("R7 no timeout flag", flags_o[3], 1'b0);
        host_scl_oe = 1'b1; wait_n(4); phase_i = 2'd0; host_scl_oe = 1'b0; wait_n(6);

        // R9: soft clear wipes flags and restarts the stretch count
        chk("R9 flag present before", flags_o[0], 1'b1);
        stretch_run(30, 15, n);
        chk("R9 stretch restarted", n, 0);
        chk("R9 flags cleared", flags_o, 4'b0000);

        // R8: override
        ovr_en = 1'b1; ovr_scl = 1'b0; ovr_sda = 1'b1;
        host_scl_oe = 1'b0; host_sda_oe = 1'b1;
        phase_i = 2'd1;
        wait_n(2);
        chk("R8 forced drive", {scl_oe_o, sda_oe_o}, 2'b10);
        ovr_scl = 1'b1;
        wait_n(10);
        tgt_scl_low = 1'b1; wait_n(3); tgt_scl_low = 1'b0;
        tgt_sda_low = 1'b1; wait_n(3); tgt_sda_low = 1'b0;
        wait_n(6);
        chk("R8 released drive", {scl_oe_o, sda_oe_o}, 2'b00);
        chk("R8 no flags in override", flags_o, 4'b0000);
        phase_i = 2'd0; ovr_en = 1'b0; host_sda_oe = 1'b0;
        wait_n(4);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule